// File: doc/BRIEF.md
# Interrupt Remapping and Validation Unit

The unit stands between interrupt-generating devices and the processors' local interrupt controllers. Every device interrupt request arrives either as a message-signalled write or as a request from the I/O interrupt controller. It carries the requesting device's identifier and a payload. The unit turns the payload into an index into a 16-entry remapping table. Each table entry names the device that owns it, a target logical processor and a vector. A request is forwarded only when the requester owns the entry it points at. The forwarded interrupt goes to the processor and vector stored in the entry, so a device cannot choose its own destination. A device that presents another device's index is rejected as a spoof.

Rejected requests are dropped. A fault record holds the kind of the most recent rejection, the requester and the raw index. Each entry keeps a saturating count of the rejected requests that pointed at it. Privileged software fills the table and reads the counters through a plain configuration port. Requests enter and interrupts leave on valid/ready streams. The input stalls while an undelivered interrupt is waiting, so no interrupt is lost under back-pressure.

Top module: `irq_remap_unit`

## Requirements
- R1: After reset, out_valid and fault_valid are 0, fault_kind is 0, every table entry is invalid, and every reject counter reads 0.
- R2: For a message-signalled request (req_is_ioapic=0), the index is the low 4 bits of req_payload. For an I/O-controller request (req_is_ioapic=1), the index is the whole req_payload, read as a redirection entry number.
- R3: An accepted request whose index is below 16, whose entry is valid and whose stored owner equals req_src_id is forwarded. In the cycle after acceptance, out_valid is 1 and out_lp and out_vec hold the entry's processor and vector, whatever the payload encoded.
- R4: An accepted request that hits a valid entry owned by a different device is dropped: no output appears and a fault of kind 2 (spoof) is recorded.
- R5: An accepted request that hits an invalid entry is dropped, and a fault of kind 1 (invalid entry) is recorded.
- R6: An I/O-controller request whose entry number is 16 or more is dropped, and a fault of kind 3 (out of range) is recorded. No reject counter changes.
- R7: In the cycle after a drop, fault_valid is 1, and fault_kind, fault_src and fault_idx (the raw index, as in R2) describe that drop. A later drop overwrites the record. fault_clr clears fault_valid and sets fault_kind to 0, but a drop accepted in the same cycle wins.
- R8: Each entry's reject counter is 4 bits wide. It counts kind 1 and kind 2 drops against that entry and saturates at 15. cfg_rd_rejects shows the counter of the entry selected by cfg_rd_idx, in the same cycle.
- R9: A configuration write stores the valid bit, owner, processor and vector at cfg_wr_idx and clears that entry's counter. A write in the same cycle as a drop against that entry wins over the increment. The write affects only requests accepted in later cycles.
- R10: req_ready equals (not out_valid) or out_ready. While out_valid is 1 and out_ready is 0, out_valid, out_lp and out_vec hold steady, and a waiting request is accepted in the cycle the held output leaves.
- R11: One device may own several entries, and each entry routes that device's requests to its own processor and vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit takes the request at this edge |
| req_is_ioapic | input | 1 | 1: I/O-controller request, 0: message-signalled |
| req_src_id | input | 16 | Requesting device identifier |
| req_payload | input | 16 | Message data, or redirection entry number |
| out_valid | output | 1 | Validated interrupt present |
| out_ready | input | 1 | Downstream takes the interrupt |
| out_lp | output | 8 | Target logical processor |
| out_vec | output | 8 | Target vector |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_idx | input | 4 | Entry to write |
| cfg_wr_valid | input | 1 | Valid bit to store |
| cfg_wr_dev | input | 16 | Owner device to store |
| cfg_wr_lp | input | 8 | Processor to store |
| cfg_wr_vec | input | 8 | Vector to store |
| cfg_rd_idx | input | 4 | Entry whose counter is shown |
| cfg_rd_rejects | output | 4 | Reject counter of that entry |
| fault_clr | input | 1 | Clear the fault record |
| fault_valid | output | 1 | A fault is recorded |
| fault_kind | output | 2 | 0 none, 1 invalid entry, 2 spoof, 3 out of range |
| fault_src | output | 16 | Requester of the recorded fault |
| fault_idx | output | 16 | Raw index of the recorded fault |

## Verification
A corrupted valid bit or owner field shows up one cycle after the next request to that entry. A good request then gets dropped with a fault, or a spoof gets through to out_valid. A wrong stored processor or vector shows on out_lp or out_vec on the first forward through that entry. A wrong counter is visible at once on cfg_rd_rejects, and a wrong back-pressure state shows as a lost, duplicated or changed interrupt while out_ready is held low.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_SPOOF   = 2'd2,
    FLT_RANGE   = 2'd3
  } fault_kind_e;
endpackage

// File: rtl/irq_remap_index.sv
module irq_remap_index #(
  parameter int PAY_W   = 16,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             is_ioapic,
  input  logic [PAY_W-1:0] payload,
  output logic [PAY_W-1:0] raw,
  output logic [IDX_W-1:0] idx,
  output logic             in_range
);
  // Message requests use the low index bits of the data; I/O-controller
  // requests use the full redirection entry number.
  always_comb begin
    raw      = is_ioapic ? payload : {{(PAY_W-IDX_W){1'b0}}, payload[IDX_W-1:0]};
    idx      = raw[IDX_W-1:0];
    in_range = (raw < PAY_W'(ENTRIES));
  end
endmodule

// File: rtl/irq_remap_table.sv
module irq_remap_table #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int DEV_W   = 16,
  parameter int LP_W    = 8,
  parameter int VEC_W   = 8,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [DEV_W-1:0] wr_dev,
  input  logic [LP_W-1:0]  wr_lp,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [DEV_W-1:0] lk_dev,
  output logic [LP_W-1:0]  lk_lp,
  output logic [VEC_W-1:0] lk_vec,
  input  logic             rej_en,
  input  logic [IDX_W-1:0] rej_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][DEV_W-1:0] dev_q;
  logic [ENTRIES-1:0][LP_W-1:0]  lp_q;
  logic [ENTRIES-1:0][VEC_W-1:0] vec_q;
  logic [ENTRIES-1:0][CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dev_q   <= '0;
      lp_q    <= '0;
      vec_q   <= '0;
      cnt_q   <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          valid_q[i] <= wr_valid;
          dev_q[i]   <= wr_dev;
          lp_q[i]    <= wr_lp;
          vec_q[i]   <= wr_vec;
          cnt_q[i]   <= '0;
        end else if (rej_en && rej_idx == IDX_W'(i) && cnt_q[i] != CNT_MAX) begin
          cnt_q[i] <= cnt_q[i] + 1'b1;
        end
      end
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_dev   = dev_q[lk_idx];
  assign lk_lp    = lp_q[lk_idx];
  assign lk_vec   = vec_q[lk_idx];
  assign rd_cnt   = cnt_q[rd_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt_chk
    // R8: a full counter stays full until its entry is rewritten
    assert_cnt_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] == CNT_MAX && !(wr_en && wr_idx == IDX_W'(g))) |=> cnt_q[g] == CNT_MAX);
    // R9: a write leaves the counter cleared
    assert_wr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(g)) |=> cnt_q[g] == '0);
  end
endmodule

// File: rtl/irq_remap_unit.sv
module irq_remap_unit
  import irq_remap_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DEV_W   = 16,
  parameter int PAY_W   = 16,
  parameter int LP_W    = 8,
  parameter int VEC_W   = 8,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_ioapic,
  input  logic [DEV_W-1:0] req_src_id,
  input  logic [PAY_W-1:0] req_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LP_W-1:0]  out_lp,
  output logic [VEC_W-1:0] out_vec,
  input  logic             cfg_wr_en,
  input  logic [IDX_W-1:0] cfg_wr_idx,
  input  logic             cfg_wr_valid,
  input  logic [DEV_W-1:0] cfg_wr_dev,
  input  logic [LP_W-1:0]  cfg_wr_lp,
  input  logic [VEC_W-1:0] cfg_wr_vec,
  input  logic [IDX_W-1:0] cfg_rd_idx,
  output logic [CNT_W-1:0] cfg_rd_rejects,
  input  logic             fault_clr,
  output logic             fault_valid,
  output logic [1:0]       fault_kind,
  output logic [DEV_W-1:0] fault_src,
  output logic [PAY_W-1:0] fault_idx
);
  logic [PAY_W-1:0] raw_idx;
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             ent_valid;
  logic [DEV_W-1:0] ent_dev;
  logic [LP_W-1:0]  ent_lp;
  logic [VEC_W-1:0] ent_vec;
  logic             accept, pass, drop;
  fault_kind_e      kind;

  irq_remap_index #(.PAY_W(PAY_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) index_i (
    .is_ioapic (req_is_ioapic),
    .payload   (req_payload),
    .raw       (raw_idx),
    .idx       (idx),
    .in_range  (in_range)
  );

  irq_remap_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .DEV_W(DEV_W), .LP_W(LP_W),
                    .VEC_W(VEC_W), .CNT_W(CNT_W)) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_idx   (cfg_wr_idx),
    .wr_valid (cfg_wr_valid),
    .wr_dev   (cfg_wr_dev),
    .wr_lp    (cfg_wr_lp),
    .wr_vec   (cfg_wr_vec),
    .lk_idx   (idx),
    .lk_valid (ent_valid),
    .lk_dev   (ent_dev),
    .lk_lp    (ent_lp),
    .lk_vec   (ent_vec),
    .rej_en   (drop && in_range),
    .rej_idx  (idx),
    .rd_idx   (cfg_rd_idx),
    .rd_cnt   (cfg_rd_rejects)
  );

  // Priority of checks: range, then valid bit, then ownership.
  always_comb begin
    if (!in_range)                kind = FLT_RANGE;
    else if (!ent_valid)          kind = FLT_INVALID;
    else if (ent_dev != req_src_id) kind = FLT_SPOOF;
    else                          kind = FLT_NONE;
  end

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;
  assign pass      = (kind == FLT_NONE);
  assign drop      = accept && !pass;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lp    <= '0;
      out_vec   <= '0;
    end else if (accept && pass) begin
      out_valid <= 1'b1;
      out_lp    <= ent_lp;
      out_vec   <= ent_vec;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_valid <= 1'b0;
      fault_kind  <= FLT_NONE;
      fault_src   <= '0;
      fault_idx   <= '0;
    end else if (drop) begin
      fault_valid <= 1'b1;
      fault_kind  <= kind;
      fault_src   <= req_src_id;
      fault_idx   <= raw_idx;
    end else if (fault_clr) begin
      fault_valid <= 1'b0;
      fault_kind  <= FLT_NONE;
    end
  end

  // R3: a validated request produces an output next cycle
  assert_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pass) |=> out_valid);
  // R4/R5: a dropped request never reaches the output
  assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !out_valid);
  // R6: out-of-range entry numbers always record a range fault
  assert_range_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_is_ioapic && req_payload >= PAY_W'(ENTRIES)) |=>
      (fault_valid && fault_kind == FLT_RANGE));
  // R7: every drop leaves a fault record
  assert_fault_logged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (fault_valid && fault_kind != FLT_NONE));
  // R10: a stalled output holds its contents
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lp) && $stable(out_vec)));
endmodule

// File: tb/irq_remap_unit_tb_top.sv
module irq_remap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_ioapic = 1'b0;
  logic        req_ready;
  logic [15:0] req_src_id = '0, req_payload = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [7:0]  out_lp, out_vec;
  logic        cfg_wr_en = 1'b0, cfg_wr_valid = 1'b0;
  logic [3:0]  cfg_wr_idx = '0, cfg_rd_idx = '0;
  logic [15:0] cfg_wr_dev = '0;
  logic [7:0]  cfg_wr_lp = '0, cfg_wr_vec = '0;
  logic [3:0]  cfg_rd_rejects;
  logic        fault_clr = 1'b0, fault_valid;
  logic [1:0]  fault_kind;
  logic [15:0] fault_src, fault_idx;

  always #10 clk = ~clk;

  irq_remap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_ioapic(req_is_ioapic), .req_src_id(req_src_id), .req_payload(req_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_lp(out_lp), .out_vec(out_vec),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_valid(cfg_wr_valid),
    .cfg_wr_dev(cfg_wr_dev), .cfg_wr_lp(cfg_wr_lp), .cfg_wr_vec(cfg_wr_vec),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_rejects(cfg_rd_rejects), .fault_clr(fault_clr),
    .fault_valid(fault_valid), .fault_kind(fault_kind), .fault_src(fault_src),
    .fault_idx(fault_idx)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit          m_valid [16];
  logic [15:0] m_dev [16];
  logic [7:0]  m_lp [16], m_vec [16];
  int          m_cnt [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] raw_of(input bit ioa, input logic [15:0] pay);
    return ioa ? pay : {12'd0, pay[3:0]};
  endfunction

  function automatic int kind_of(input bit ioa, input logic [15:0] src, input logic [15:0] pay);
    logic [15:0] r = raw_of(ioa, pay);
    if (r >= 16) return 3;
    if (!m_valid[r[3:0]]) return 1;
    if (m_dev[r[3:0]] != src) return 2;
    return 0;
  endfunction

  task automatic cfg_write(input int i, input bit v, input logic [15:0] d, input logic [7:0] lp, input logic [7:0] vec);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_idx = 4'(i); cfg_wr_valid = v;
    cfg_wr_dev = d; cfg_wr_lp = lp; cfg_wr_vec = vec;
    @(negedge clk);
    cfg_wr_en = 0;
    m_valid[i] = v; m_dev[i] = d; m_lp[i] = lp; m_vec[i] = vec; m_cnt[i] = 0;
  endtask

  // One request with out_ready high; checks output, fault record and counter.
  task automatic send(input bit ioa, input logic [15:0] src, input logic [15:0] pay, input string tag);
    int k = kind_of(ioa, src, pay);
    logic [15:0] r = raw_of(ioa, pay);
    @(negedge clk);
    req_valid = 1; req_is_ioapic = ioa; req_src_id = src; req_payload = pay;
    @(negedge clk);
    req_valid = 0; fault_clr = 0;
    if (k == 0) begin
      chk(out_valid == 1, {tag, " R3 out_valid"}, 32'(out_valid), 1);
      chk(out_lp == m_lp[r[3:0]], {tag, " R3 out_lp"}, 32'(out_lp), 32'(m_lp[r[3:0]]));
      chk(out_vec == m_vec[r[3:0]], {tag, " R3 out_vec"}, 32'(out_vec), 32'(m_vec[r[3:0]]));
    end else begin
      if (k != 3 && m_cnt[r[3:0]] < 15) m_cnt[r[3:0]]++;
      chk(out_valid == 0, {tag, " R4 R5 R6 dropped"}, 32'(out_valid), 0);
      chk(fault_valid == 1 && fault_kind == 2'(k), {tag, " R7 fault kind"}, 32'(fault_kind), 32'(k));
      chk(fault_src == src && fault_idx == r, {tag, " R7 fault src/idx"},
          {fault_src, fault_idx}, {src, r});
    end
    if (r < 16) begin
      cfg_rd_idx = r[3:0];
      #1;
      chk(cfg_rd_rejects == 4'(m_cnt[r[3:0]]), {tag, " R8 counter"},
          32'(cfg_rd_rejects), 32'(m_cnt[r[3:0]]));
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    for (int i = 0; i < 16; i++) begin
      m_valid[i] = 0; m_dev[i] = 0; m_lp[i] = 0; m_vec[i] = 0; m_cnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && fault_valid == 0 && fault_kind == 0, "R1 outputs after reset",
        {out_valid, fault_valid, fault_kind}, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin
        cfg_rd_idx = 4'(i); #1;
        if (cfg_rd_rejects != 0) bad++;
      end
      chk(bad == 0, "R1 counters zero", 32'(bad), 0);
    end
    send(0, 16'h0100, 16'h0007, "R1 invalid after reset R5");

    // R3 R11: one device owns several entries with distinct targets
    cfg_write(1, 1, 16'h00A1, 8'd1, 8'h80);
    cfg_write(2, 1, 16'h00A1, 8'd2, 8'h82);
    cfg_write(3, 1, 16'h00B2, 8'd1, 8'h81);
    send(0, 16'h00A1, 16'h4562, "R11 entry2 R2 low bits");
    send(0, 16'h00A1, 16'hFFF1, "R11 entry1");
    send(1, 16'h00A1, 16'h0002, "R2 ioapic entry2");
    // R4: spoof of another device's entry
    send(0, 16'h00B2, 16'h0002, "R4 spoof");
    // R6: out-of-range redirection entry, counters untouched
    send(1, 16'h00A1, 16'h0010, "R6 range 16");
    send(1, 16'h00B2, 16'h1234, "R6 range large");

    // R7: fault_clr clears; same-cycle drop wins
    @(negedge clk); fault_clr = 1;
    @(negedge clk); fault_clr = 0;
    chk(fault_valid == 0 && fault_kind == 0, "R7 fault cleared", {fault_valid, fault_kind}, 0);
    @(negedge clk); fault_clr = 1;
    send(0, 16'h00C3, 16'h0003, "R7 clear collides with drop");

    // R8: saturation at 15, R9: write clears
    cfg_write(5, 1, 16'h0010, 8'd3, 8'h90);
    for (int i = 0; i < 18; i++) send(0, 16'h0099, 16'h0005, "R8 saturate");
    cfg_rd_idx = 4'd5; #1;
    chk(cfg_rd_rejects == 4'd15, "R8 saturated value", 32'(cfg_rd_rejects), 15);
    cfg_write(5, 1, 16'h0099, 8'd4, 8'h91);
    cfg_rd_idx = 4'd5; #1;
    chk(cfg_rd_rejects == 4'd0, "R9 write clears counter", 32'(cfg_rd_rejects), 0);
    send(0, 16'h0099, 16'h0005, "R9 new owner accepted");

    // R10: back-pressure
    @(negedge clk);
    out_ready = 0;
    req_valid = 1; req_is_ioapic = 0; req_src_id = 16'h00A1; req_payload = 16'h0001;
    @(negedge clk);
    req_payload = 16'h0002;
    chk(req_ready == 0 && out_valid == 1, "R10 stall ready low", {req_ready, out_valid}, 1);
    repeat (3) @(negedge clk);
    chk(out_valid == 1 && out_lp == 8'd1 && out_vec == 8'h80, "R10 held output",
        {out_valid, out_lp, out_vec}, {1'b1, 8'd1, 8'h80});
    out_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(out_valid == 1 && out_lp == 8'd2 && out_vec == 8'h82, "R10 waiting request delivered",
        {out_valid, out_lp, out_vec}, {1'b1, 8'd2, 8'h82});
    @(negedge clk);
    chk(out_valid == 0, "R10 no duplicate", 32'(out_valid), 0);

    // Random mix against the model
    for (int i = 0; i < 12; i++)
      cfg_write(i, 1, 16'h0100 + 16'($urandom_range(0, 2)), 8'($urandom), 8'($urandom));
    for (int i = 0; i < 300; i++) begin
      bit ioa = 1'($urandom_range(0, 1));
      logic [15:0] pay = ioa ? 16'($urandom_range(0, 19)) : 16'($urandom);
      send(ioa, 16'h0100 + 16'($urandom_range(0, 2)), pay, "random R2 R3 R4 R5 R6");
    end

    done = 1;
    report();
  end
endmodule